// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the control logic on the memory side of a parallel read port that supports bursts. A host pulls the active-low address-valid strobe low while the chip is enabled. On the first active clock edge of that low period the block captures the start word address. It then waits a programmable number of cycles and presents one word per active clock edge from an internal word array. A ready output tells the host when the data pins hold a fresh word. In linear mode the ready output also drops for a single stall cycle whenever the running address crosses a 64-word page.

Two burst orders are available. Linear mode walks upward through the address space and rolls over at the top. Wrap mode circles inside the aligned group of eight words that holds the start address. A configuration input chooses whether ready comes with the word or one cycle before it. A handshaking option adds one initial cycle when the start address is odd. The configuration fields are plain inputs. A parameter selects whether the rising or the falling clock edge is the active one. The data pins are driven only in the data phase, and only while both the chip enable and the output enable are asserted.

Top module: `burst_read_seq`

## Requirements
- R1: After reset, with no address latched, `dq_oe` and `rdy` are 0 and `dq_out` is all zeros.
- R2: An address is captured only on the first active edge at which `avd_n` is low, `ce_n` is low and `avd_n` was high at the previous edge. Further edges in the same low period do not capture `addr_in` again.
- R3: Call the capture edge edge 0. The first word is on `dq_out` in the cycle after edge T, where T is the value of `cfg_lat` (2 to 7). The values 0 and 1 count as 2. `dq_oe` stays 0 before that cycle.
- R4: When `cfg_hs_odd` is 1 and bit 0 of the start address is 1, T is one cycle longer. An even start address, or `cfg_hs_odd` = 0, adds nothing.
- R5: In linear mode (`cfg_wrap` = 0) each new word has the address of the one before plus one, modulo 2^AW. Address 2^AW-1 is followed by address 0.
- R6: In linear mode, after the word whose address has its low six bits all ones, there is exactly one stall cycle. In that cycle `rdy` is low (same-cycle mode) and the previous word stays on `dq_out`. The next word follows the stall cycle.
- R7: In wrap mode (`cfg_wrap` = 1) only the low three address bits advance, modulo 8. The order is ascending from the start word and returns to the group's lowest word after its highest. The burst runs without end and has no stall cycles.
- R8: With `cfg_rdy_early` = 0, `rdy` is 1 exactly in the cycles that show a new word. With `cfg_rdy_early` = 1, `rdy` is 1 exactly in the cycles that come just before such a cycle. `rdy` is 0 whenever `ce_n` is 1.
- R9: `dq_oe` is 1 only when `ce_n` = 0, `oe_n` = 0 and the block is in the data phase. `dq_out` is zero whenever `dq_oe` is 0. Raising `oe_n` does not pause or shift the burst.
- R10: If `ce_n` is high at an active edge, the burst is aborted and the block goes idle. It stays idle, with `dq_oe` and `rdy` at 0, until a new address is captured.
- R11: Capturing a new address during a burst drops the old burst and starts the new one with its full initial wait.
- R12: The word stored at address a is the low DW bits of (a * 40503) XOR 0x5A5A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; the active edge is chosen by parameter ACTIVE_FALL |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| avd_n | input | 1 | Address-valid strobe, active low |
| addr_in | input | AW | Start word address |
| cfg_lat | input | 3 | Initial wait in cycles (2 to 7) |
| cfg_wrap | input | 1 | 1 selects the 8-word wrapping burst |
| cfg_rdy_early | input | 1 | 1 makes ready lead its data by one cycle |
| cfg_hs_odd | input | 1 | 1 adds one wait cycle for odd start addresses |
| dq_out | output | DW | Data word, zero when not driven |
| dq_oe | output | 1 | Output enable for the data tri-state buffer |
| rdy | output | 1 | Ready: marks valid data |

## Verification
The assertions check on every cycle that the data pins are only driven while both enables are asserted. They also check the one-step address advance in each burst mode, and that a stall happens only on a page's last word and lasts only one cycle. Further checks cover the latency count from the capture edge to the data phase, that an early ready is always followed by a fresh word, and that a chip-enable abort ends the data phase. Only the bench's scenarios show the actual word values and the full cycle-by-cycle ready pattern around stalls. The same holds for rollover at the top of the address space, for ignored extra edges of a held strobe, and for the restart when a new address arrives mid-burst.

// File: rtl/brst_pkg.sv
package brst_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  localparam int unsigned GROUP_BITS = 3;
  localparam int unsigned PAGE_BITS  = 6;

  // Cycles from the capture edge to the first word.
  function automatic logic [3:0] initial_wait(input logic [2:0] lat, input logic odd_penalty);
    logic [3:0] base;
    base = (lat < 3'd2) ? 4'd2 : {1'b0, lat};
    return base + {3'b000, odd_penalty};
  endfunction

  // Content of the word array at a given address.
  function automatic logic [31:0] word_seed(input logic [31:0] a);
    return (a * 32'd40503) ^ 32'h0000_5A5A;
  endfunction

endpackage

// File: rtl/brst_strobe.sv
module brst_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic avd_n,
  output logic start_evt
);

  logic avd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) avd_q <= 1'b1;
    else        avd_q <= avd_n;
  end

  // Only the first edge of a low strobe period captures.
  assign start_evt = !ce_n && !avd_n && avd_q;

endmodule

// File: rtl/brst_addr_step.sv
module brst_addr_step #(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0] cur,
  input  logic          wrap_mode,
  output logic [AW-1:0] nxt,
  output logic          page_cross
);

  localparam int unsigned GB = brst_pkg::GROUP_BITS;
  localparam int unsigned PB = brst_pkg::PAGE_BITS;

  logic [AW-1:0] lin_nxt;
  logic [AW-1:0] grp_nxt;
  logic          lin_at_page;

  assign lin_nxt = cur + 1'b1;
  assign grp_nxt = {cur[AW-1:GB], cur[GB-1:0] + 1'b1};

  generate
    if (AW > PB) begin : g_paged
      assign lin_at_page = (lin_nxt[PB-1:0] == '0);
    end else begin : g_flat
      assign lin_at_page = (lin_nxt == '0);
    end
  endgenerate

  assign nxt        = wrap_mode ? grp_nxt : lin_nxt;
  assign page_cross = !wrap_mode && lin_at_page;

endmodule

// File: rtl/brst_word_store.sv
module brst_word_store #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DW'(brst_pkg::word_seed(32'(i)));
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/brst_seq.sv
module brst_seq #(
  parameter int unsigned AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              start_evt,
  input  logic [AW-1:0]     addr_in,
  input  logic [2:0]        cfg_lat,
  input  logic              cfg_hs_odd,
  input  logic [AW-1:0]     nxt_addr,
  input  logic              nxt_cross,
  output brst_pkg::phase_t  phase,
  output logic [AW-1:0]     cur_addr,
  output logic              stall,
  output logic [3:0]        wait_left
);

  import brst_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cur_addr  <= '0;
      stall     <= 1'b0;
      wait_left <= '0;
    end else if (ce_n) begin
      phase     <= PH_IDLE;
      stall     <= 1'b0;
      wait_left <= '0;
    end else if (start_evt) begin
      phase     <= PH_WAIT;
      cur_addr  <= addr_in;
      stall     <= 1'b0;
      wait_left <= initial_wait(cfg_lat, cfg_hs_odd & addr_in[0]);
    end else begin
      unique case (phase)
        PH_WAIT: begin
          if (wait_left == 4'd1) begin
            phase     <= PH_DATA;
            wait_left <= '0;
          end else begin
            wait_left <= wait_left - 4'd1;
          end
        end
        PH_DATA: begin
          if (!stall && nxt_cross) begin
            stall <= 1'b1;
          end else begin
            stall    <= 1'b0;
            cur_addr <= nxt_addr;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq #(
  parameter int unsigned AW          = 8,
  parameter int unsigned DW          = 16,
  parameter bit          ACTIVE_FALL = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          avd_n,
  input  logic [AW-1:0] addr_in,
  input  logic [2:0]    cfg_lat,
  input  logic          cfg_wrap,
  input  logic          cfg_rdy_early,
  input  logic          cfg_hs_odd,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          rdy
);

  import brst_pkg::*;

  logic          core_clk;
  logic          start_evt;
  phase_t        phase;
  logic [AW-1:0] cur_addr;
  logic [AW-1:0] nxt_addr;
  logic          nxt_cross;
  logic          stall;
  logic [3:0]    wait_left;
  logic [DW-1:0] word;
  logic          phase_data;
  logic          beat_now;
  logic          beat_next;

  generate
    if (ACTIVE_FALL) begin : g_fall_edge
      assign core_clk = ~clk;
    end else begin : g_rise_edge
      assign core_clk = clk;
    end
  endgenerate

  brst_strobe u_strobe (
    .clk       (core_clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .avd_n     (avd_n),
    .start_evt (start_evt)
  );

  brst_addr_step #(.AW(AW)) u_step (
    .cur        (cur_addr),
    .wrap_mode  (cfg_wrap),
    .nxt        (nxt_addr),
    .page_cross (nxt_cross)
  );

  brst_seq #(.AW(AW)) u_seq (
    .clk        (core_clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .start_evt  (start_evt),
    .addr_in    (addr_in),
    .cfg_lat    (cfg_lat),
    .cfg_hs_odd (cfg_hs_odd),
    .nxt_addr   (nxt_addr),
    .nxt_cross  (nxt_cross),
    .phase      (phase),
    .cur_addr   (cur_addr),
    .stall      (stall),
    .wait_left  (wait_left)
  );

  brst_word_store #(.AW(AW), .DW(DW)) u_store (
    .rd_addr (cur_addr),
    .rd_data (word)
  );

  assign phase_data = (phase == PH_DATA);
  assign beat_now   = phase_data && !stall;
  assign beat_next  = ((phase == PH_WAIT) && (wait_left == 4'd1)) ||
                      (phase_data && (stall || !nxt_cross));

  assign rdy    = !ce_n && (cfg_rdy_early ? beat_next : beat_now);
  assign dq_oe  = !ce_n && !oe_n && phase_data;
  assign dq_out = dq_oe ? word : '0;

endmodule

// File: rtl/brst_checker.sv
module brst_checker #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic [AW-1:0] addr_in,
  input logic [2:0]    cfg_lat,
  input logic          cfg_wrap,
  input logic          cfg_rdy_early,
  input logic          cfg_hs_odd,
  input logic          start_evt,
  input logic          phase_data,
  input logic          stall,
  input logic [AW-1:0] cur_addr,
  input logic          dq_oe,
  input logic          rdy
);

  localparam int unsigned PB = (AW < 6) ? AW : 6;

  logic       armed;
  logic [3:0] since;
  logic [3:0] exp_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      since    <= '0;
      exp_wait <= '0;
    end else if (ce_n) begin
      armed <= 1'b0;
    end else if (start_evt) begin
      armed    <= 1'b1;
      since    <= '0;
      exp_wait <= ((cfg_lat == 3'd0 || cfg_lat == 3'd1) ? 4'd2 : {1'b0, cfg_lat})
                  + ((cfg_hs_odd && addr_in[0]) ? 4'd1 : 4'd0);
    end else if (armed) begin
      if (since != 4'hF) since <= since + 4'd1;
      if (phase_data) armed <= 1'b0;
    end
  end

  // R3 and R4: first data cycle lands exactly after the programmed wait
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(phase_data)) |-> (since == exp_wait));

  // R5: linear step of one word
  p_linear_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_data && !stall && !cfg_wrap && !start_evt && !ce_n && !(&cur_addr[PB-1:0]))
    |=> (cur_addr == AW'($past(cur_addr) + 1'b1)));

  // R6: a stall only follows a page's last word
  p_stall_at_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (&cur_addr[PB-1:0]));

  // R6: a stall lasts one cycle
  p_stall_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !ce_n && !start_evt) |=> (!stall && phase_data));

  // R7: wrap stays inside its group and steps by one
  p_wrap_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_data && cfg_wrap && !stall && !start_evt && !ce_n)
    |=> ((cur_addr[AW-1:3] == $past(cur_addr[AW-1:3])) &&
         (cur_addr[2:0] == $past(cur_addr[2:0]) + 3'd1)));

  // R8: an early ready is always followed by a fresh word
  p_rdy_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdy_early && rdy && !start_evt && !ce_n) |=> (phase_data && !stall));

  // R9: pins stay released without both enables
  p_oe_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> !dq_oe);

  // R10: chip-enable abort ends the data phase
  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (!phase_data && !stall));

endmodule

bind burst_read_seq brst_checker #(.AW(AW)) u_brst_chk (
  .clk           (core_clk),
  .rst_n         (rst_n),
  .ce_n          (ce_n),
  .oe_n          (oe_n),
  .addr_in       (addr_in),
  .cfg_lat       (cfg_lat),
  .cfg_wrap      (cfg_wrap),
  .cfg_rdy_early (cfg_rdy_early),
  .cfg_hs_odd    (cfg_hs_odd),
  .start_evt     (start_evt),
  .phase_data    (phase_data),
  .stall         (stall),
  .cur_addr      (cur_addr),
  .dq_oe         (dq_oe),
  .rdy           (rdy)
);

// File: tb/tb_burst_read_seq.sv
module tb_burst_read_seq;

  localparam int AW    = 8;
  localparam int DW    = 16;
  localparam int DEPTH = 256;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, oe_n, avd_n;
  logic [AW-1:0] addr_in;
  logic [2:0]    cfg_lat;
  logic          cfg_wrap, cfg_rdy_early, cfg_hs_odd;
  logic [DW-1:0] dq_out;
  logic          dq_oe, rdy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int vq[$];
  int aq[$];

  always #4 clk = ~clk;

  burst_read_seq #(.AW(AW), .DW(DW), .ACTIVE_FALL(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .avd_n(avd_n),
    .addr_in(addr_in), .cfg_lat(cfg_lat), .cfg_wrap(cfg_wrap),
    .cfg_rdy_early(cfg_rdy_early), .cfg_hs_odd(cfg_hs_odd),
    .dq_out(dq_out), .dq_oe(dq_oe), .rdy(rdy)
  );

  // R12: array content, restated with wide integer arithmetic
  function automatic logic [15:0] mem_word(input int a);
    longint p;
    p = (longint'(a) * 40503) % 65536;
    return 16'(p) ^ 16'h5A5A;
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Expected timeline: per cycle after the capture edge, is a new word shown, and which address is on the pins
  task automatic build(input int start, input int t0, input bit wrap, input int n);
    int a;
    vq.delete();
    aq.delete();
    for (int c = 0; c < t0; c++) begin
      vq.push_back(0);
      aq.push_back(0);
    end
    a = start;
    while (vq.size() < n + 2) begin
      vq.push_back(1);
      aq.push_back(a);
      if (wrap) begin
        a = (a / 8) * 8 + ((a % 8) + 1) % 8;
      end else begin
        int nx;
        nx = (a + 1) % DEPTH;
        if (nx % 64 == 0) begin
          vq.push_back(0);
          aq.push_back(a);
        end
        a = nx;
      end
    end
  endtask

  task automatic run_burst(input int start, input int lat, input bit wrap, input bit early,
                           input bit hs, input int ncyc, input int hold, input int gap_at,
                           input string tag);
    int t0;
    t0 = ((lat < 2) ? 2 : lat) + ((hs && (start % 2 == 1)) ? 1 : 0);
    build(start, t0, wrap, ncyc);
    @(negedge clk);
    cfg_lat = 3'(lat);
    cfg_wrap = wrap;
    cfg_rdy_early = early;
    cfg_hs_odd = hs;
    ce_n = 1'b0;
    oe_n = 1'b0;
    avd_n = 1'b0;
    addr_in = AW'(start);
    for (int c = 0; c < ncyc; c++) begin
      bit exp_oe;
      bit exp_rdy;
      @(posedge clk);
      @(negedge clk);
      avd_n = (c < hold) ? 1'b0 : 1'b1;
      if (c < hold) addr_in = AW'(start ^ 8'h55);
      oe_n = (gap_at >= 0 && c >= gap_at && c < gap_at + 2) ? 1'b1 : 1'b0;
      #1;
      exp_oe  = (c >= t0) && !oe_n;
      exp_rdy = early ? (vq[c + 1] != 0) : (vq[c] != 0);
      check(tag, "dq_oe", dq_oe, exp_oe);
      check(tag, "rdy", rdy, exp_rdy);
      check(tag, "dq_out", dq_out, exp_oe ? mem_word(aq[c]) : 0);
    end
  endtask

  task automatic expect_idle(input int n, input string tag);
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      @(negedge clk);
      #1;
      check(tag, "idle dq_oe", dq_oe, 0);
      check(tag, "idle rdy", rdy, 0);
    end
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ce_n = 1'b1; oe_n = 1'b1; avd_n = 1'b1; addr_in = '0;
    cfg_lat = 3'd4; cfg_wrap = 1'b0; cfg_rdy_early = 1'b0; cfg_hs_odd = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    ce_n = 1'b0; oe_n = 1'b0;
    #1;
    // R1 reset state
    check("R1", "dq_oe", dq_oe, 0);
    check("R1", "rdy", rdy, 0);
    check("R1", "dq_out", dq_out, 0);
    expect_idle(3, "R1");

    run_burst(10, 4, 0, 0, 0, 12, 0, -1, "R5/R12");
    run_burst(3, 2, 0, 0, 0, 8, 0, -1, "R3");
    run_burst(3, 7, 0, 0, 0, 12, 0, -1, "R3");
    run_burst(3, 0, 0, 0, 0, 8, 0, -1, "R3");
    run_burst(3, 1, 0, 1, 0, 8, 0, -1, "R3");
    run_burst(60, 3, 0, 0, 0, 12, 0, -1, "R6");
    run_burst(125, 2, 0, 0, 0, 10, 0, -1, "R6");
    run_burst(61, 3, 0, 1, 0, 12, 0, -1, "R8");
    run_burst(20, 5, 0, 1, 0, 10, 0, -1, "R8");
    run_burst(254, 2, 0, 0, 0, 8, 0, -1, "R5");
    run_burst(6, 4, 1, 0, 0, 22, 0, -1, "R7");
    run_burst(61, 3, 1, 1, 0, 22, 0, -1, "R7");
    run_burst(5, 3, 0, 0, 1, 10, 0, -1, "R4");
    run_burst(4, 3, 0, 0, 1, 10, 0, -1, "R4");
    run_burst(5, 3, 0, 0, 0, 10, 0, -1, "R4");
    run_burst(7, 7, 1, 1, 1, 14, 0, -1, "R4");
    run_burst(40, 4, 0, 0, 0, 10, 2, -1, "R2");
    run_burst(30, 2, 0, 0, 0, 12, 0, 5, "R9");
    // R11: wrap burst cut short by a new capture
    run_burst(13, 2, 1, 0, 0, 9, 0, -1, "R11");
    run_burst(100, 5, 0, 0, 0, 10, 0, -1, "R11");

    // R10: abort with chip enable, then stay idle
    run_burst(50, 2, 0, 1, 0, 6, 0, -1, "R10");
    @(negedge clk);
    ce_n = 1'b1;
    #1;
    check("R10", "dq_oe on ce high", dq_oe, 0);
    check("R10", "rdy on ce high", rdy, 0);
    @(negedge clk);
    ce_n = 1'b0;
    #1;
    check("R10", "dq_oe after abort", dq_oe, 0);
    expect_idle(5, "R10");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule